// File: doc/BRIEF.md
# External I/O Bank Strobe Generator

This block sits between a simple processor I/O bus and the peripheral chips hung off it. Each I/O access is steered to one of eight banks by the top three address bits. A per-bank control register sets which access directions the bank answers (any, read only, write only, or either), how many wait states the access takes, and whether writes are blocked. The bank's dedicated pin then carries an active-low strobe for the length of the access, while the five lowest address bits pass through to pick a register inside the peripheral. The processor holds its request until `io_ready` is high at a clock edge, and that edge ends the access.

Every pin can also work as a general-purpose output or as an undriven input. A direction register and a function register pick the mode per pin, and a data register supplies the value driven in plain output mode. All configuration registers are written through a small select/data port. A write takes effect from the next access and does not change an access already under way.

Top module: `iob_strobe_gen`

## Requirements
- R1: The bank number is `io_addr[15:13]`. Address 0x4000 selects bank 2 and 0xC000 selects bank 6. Only the pin with the same index as the bank may strobe.
- R2: `io_addr_lo` always equals `io_addr[4:0]`.
- R3: Control bits [7:6] give the wait count W: 00=1, 01=3, 10=7, 11=15. A matching access drives its strobe low for 1+W cycles, starting in the first cycle of the request. `io_ready` is low for the first W of those cycles and high in the last.
- R4: Control bits [5:4] give the strobe type: 00 and 11 match both reads and writes, 01 matches reads only, 10 matches writes only.
- R5: An access whose direction the bank's type does not match drives no strobe, and `io_ready` is high in its first cycle.
- R6: Control bit 3 is write protect. A write to a protected bank drives no strobe and completes in its first cycle. Reads from that bank behave as though the bit were clear.
- R7: A pin carries the strobe only when both its direction bit and its function bit are set, and then it idles high. With the direction bit set and the function bit clear, it drives its data-register bit with `pin_oe`=1. With the direction bit clear, `pin_oe`=0.
- R8: After reset, all control, direction, function and data registers are zero. `pin_oe` is 0, `io_ready` is 1, and bank accesses use type 00 with one wait state.
- R9: A configuration write is used from the next access on. An access starting in the same cycle as the write uses the old value. A write landing during an access changes neither its strobe nor its length.
- R10: `cfg_sel` 0 to 7 write bank control registers 0 to 7, 8 writes the direction register, 9 the function register and 10 the data register. Values 11 to 15 change nothing.
- R11: At most one strobe is low in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| io_addr | input | 16 | I/O address, held through the access |
| io_rd | input | 1 | I/O read request, held until ready |
| io_wr | input | 1 | I/O write request, held until ready |
| io_ready | output | 1 | High in the final cycle of an access |
| io_addr_lo | output | 5 | Low address bits to the peripheral |
| cfg_wr | input | 1 | Configuration register write enable |
| cfg_sel | input | 4 | Configuration register select |
| cfg_wdata | input | 8 | Configuration write data |
| pin_out | output | 8 | Pin values (strobe or GPIO data) |
| pin_oe | output | 8 | Pin output enables |

## Verification
Two functions can fall in the same clock cycle: a configuration write and the start of an access to the bank it reconfigures. The bench issues both in one cycle and expects the old wait count. The next access must then show the new wait count. A second case writes a new wait count and clears the pin's function bit in the middle of a long access; the scoreboard expects the strobe pin and the full original length unchanged.

// File: rtl/iob_pkg.sv
package iob_pkg;

   localparam int WAIT_W = 4;

   typedef enum logic [1:0] {
      KIND_ANY  = 2'b00,
      KIND_RD   = 2'b01,
      KIND_WR   = 2'b10,
      KIND_BOTH = 2'b11
   } strobe_kind_e;

   typedef struct packed {
      logic [1:0]   wait_sel;
      strobe_kind_e kind;
      logic         wprot;
   } bank_ctrl_t;

   localparam int CTRL_W = $bits(bank_ctrl_t);

   function automatic logic [WAIT_W-1:0] wait_cycles(input logic [1:0] sel);
      return WAIT_W'((5'd2 << sel) - 5'd1);
   endfunction

endpackage

// File: rtl/iob_regs.sv
module iob_regs
   import iob_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int SEL_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          cfg_wr,
   input  logic [SEL_W-1:0]              cfg_sel,
   input  logic [DATA_W-1:0]             cfg_wdata,
   output bank_ctrl_t [NBANK-1:0]        ctrl_q,
   output logic [NBANK-1:0]              ddr_q,
   output logic [NBANK-1:0]              func_q,
   output logic [NBANK-1:0]              gdat_q
);

   localparam int SEL_DDR  = NBANK;
   localparam int SEL_FUNC = NBANK + 1;
   localparam int SEL_GDAT = NBANK + 2;

   for (genvar b = 0; b < NBANK; b++) begin : g_ctrl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ctrl_q[b] <= '0;
         end else if (cfg_wr && cfg_sel == SEL_W'(b)) begin
            ctrl_q[b] <= bank_ctrl_t'(cfg_wdata[DATA_W-1 -: CTRL_W]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ddr_q  <= '0;
         func_q <= '0;
         gdat_q <= '0;
      end else if (cfg_wr) begin
         if (cfg_sel == SEL_W'(SEL_DDR))  ddr_q  <= cfg_wdata[NBANK-1:0];
         if (cfg_sel == SEL_W'(SEL_FUNC)) func_q <= cfg_wdata[NBANK-1:0];
         if (cfg_sel == SEL_W'(SEL_GDAT)) gdat_q <= cfg_wdata[NBANK-1:0];
      end
   end

endmodule

// File: rtl/iob_seq.sv
module iob_seq
   import iob_pkg::*;
#(
   parameter int NBANK  = 8,
   parameter int BANK_W = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               req_rd,
   input  logic               req_wr,
   input  logic [BANK_W-1:0]  bank,
   input  bank_ctrl_t         ctrl_cur,
   input  logic               pin_en_cur,
   output logic               ready,
   output logic [NBANK-1:0]   strobe_n,
   output logic               busy,
   output logic [BANK_W-1:0]  act_bank,
   output logic               act_en
);

   logic              match;
   logic              fire;
   logic [WAIT_W-1:0] cnt;

   always_comb begin
      unique case (ctrl_cur.kind)
         KIND_RD: match = req_rd;
         KIND_WR: match = req_wr;
         default: match = req_rd | req_wr;
      endcase
   end

   assign fire  = !busy && match && !(ctrl_cur.wprot && req_wr);
   assign ready = busy ? (cnt == WAIT_W'(1)) : !fire;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy     <= 1'b0;
         cnt      <= '0;
         act_bank <= '0;
         act_en   <= 1'b0;
      end else if (fire) begin
         busy     <= 1'b1;
         cnt      <= wait_cycles(ctrl_cur.wait_sel);
         act_bank <= bank;
         act_en   <= pin_en_cur;
      end else if (busy) begin
         if (cnt == WAIT_W'(1)) busy <= 1'b0;
         cnt <= cnt - WAIT_W'(1);
      end
   end

   for (genvar b = 0; b < NBANK; b++) begin : g_strobe
      assign strobe_n[b] = !((fire && bank == BANK_W'(b)) ||
                             (busy && act_bank == BANK_W'(b)));
   end

endmodule

// File: rtl/iob_pinmux.sv
module iob_pinmux #(
   parameter int NBANK  = 8,
   parameter int BANK_W = 3
) (
   input  logic               busy,
   input  logic [BANK_W-1:0]  act_bank,
   input  logic               act_en,
   input  logic [NBANK-1:0]   strobe_n,
   input  logic [NBANK-1:0]   ddr_q,
   input  logic [NBANK-1:0]   func_q,
   input  logic [NBANK-1:0]   gdat_q,
   output logic [NBANK-1:0]   pin_out,
   output logic [NBANK-1:0]   pin_oe
);

   for (genvar i = 0; i < NBANK; i++) begin : g_pin
      logic held;
      logic en;
      assign held       = busy && act_bank == BANK_W'(i);
      assign en         = held ? act_en : (ddr_q[i] & func_q[i]);
      assign pin_out[i] = en ? strobe_n[i] : gdat_q[i];
      assign pin_oe[i]  = en | ddr_q[i];
   end

endmodule

// File: rtl/iob_strobe_gen.sv
module iob_strobe_gen
   import iob_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int BANK_W = 3,
   parameter int SUB_W  = 5,
   parameter int SEL_W  = 4,
   parameter int DATA_W = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [ADDR_W-1:0]         io_addr,
   input  logic                      io_rd,
   input  logic                      io_wr,
   output logic                      io_ready,
   output logic [SUB_W-1:0]          io_addr_lo,
   input  logic                      cfg_wr,
   input  logic [SEL_W-1:0]          cfg_sel,
   input  logic [DATA_W-1:0]         cfg_wdata,
   output logic [(1<<BANK_W)-1:0]    pin_out,
   output logic [(1<<BANK_W)-1:0]    pin_oe
);

   localparam int NBANK = 1 << BANK_W;

   if (ADDR_W < BANK_W + SUB_W) begin : g_bad_addr
      $fatal(1, "address too narrow for bank and sub-address fields");
   end
   if (DATA_W < NBANK || DATA_W < CTRL_W) begin : g_bad_data
      $fatal(1, "data width too narrow for configuration registers");
   end
   if ((1 << SEL_W) < NBANK + 3) begin : g_bad_sel
      $fatal(1, "select width cannot reach all configuration registers");
   end

   logic [BANK_W-1:0]      bank;
   bank_ctrl_t [NBANK-1:0] ctrl_q;
   bank_ctrl_t             ctrl_cur;
   logic [NBANK-1:0]       ddr_q, func_q, gdat_q;
   logic [NBANK-1:0]       strobe_n;
   logic                   busy;
   logic [BANK_W-1:0]      act_bank;
   logic                   act_en;
   logic                   unused_mid;

   assign bank       = io_addr[ADDR_W-1 -: BANK_W];
   assign io_addr_lo = io_addr[SUB_W-1:0];
   assign ctrl_cur   = ctrl_q[bank];
   assign unused_mid = ^io_addr[ADDR_W-BANK_W-1:SUB_W];

   iob_regs #(.NBANK(NBANK), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
      .cfg_wdata(cfg_wdata), .ctrl_q(ctrl_q), .ddr_q(ddr_q),
      .func_q(func_q), .gdat_q(gdat_q)
   );

   iob_seq #(.NBANK(NBANK), .BANK_W(BANK_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .req_rd(io_rd), .req_wr(io_wr),
      .bank(bank), .ctrl_cur(ctrl_cur),
      .pin_en_cur(ddr_q[bank] & func_q[bank]),
      .ready(io_ready), .strobe_n(strobe_n), .busy(busy),
      .act_bank(act_bank), .act_en(act_en)
   );

   iob_pinmux #(.NBANK(NBANK), .BANK_W(BANK_W)) u_pinmux (
      .busy(busy), .act_bank(act_bank), .act_en(act_en),
      .strobe_n(strobe_n), .ddr_q(ddr_q), .func_q(func_q),
      .gdat_q(gdat_q), .pin_out(pin_out), .pin_oe(pin_oe)
   );

endmodule

// File: rtl/iob_strobe_gen_chk.sv
module iob_strobe_gen_chk
   import iob_pkg::*;
#(
   parameter int NBANK = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             io_rd,
   input logic             io_wr,
   input logic             io_ready,
   input logic [NBANK-1:0] strobe_n,
   input logic             busy,
   input bank_ctrl_t       ctrl_cur
);

   logic [4:0] low_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              low_run <= '0;
      else if (io_ready)       low_run <= '0;
      else if (low_run != '1)  low_run <= low_run + 5'd1;
   end

   p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~strobe_n));

   p_wait_has_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !io_ready |-> (~strobe_n != '0));

   p_wait_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      low_run <= 5'd15);

   p_strobe_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !io_ready |=> $stable(strobe_n));

   p_wprot_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && io_wr && !io_rd && ctrl_cur.wprot) |-> (io_ready && (&strobe_n)));

   p_idle_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !io_rd && !io_wr) |-> (io_ready && (&strobe_n)));

endmodule

bind iob_strobe_gen iob_strobe_gen_chk #(.NBANK(NBANK)) u_chk (
   .clk(clk), .rst_n(rst_n), .io_rd(io_rd), .io_wr(io_wr),
   .io_ready(io_ready), .strobe_n(strobe_n), .busy(busy),
   .ctrl_cur(ctrl_cur)
);

// File: tb/iob_strobe_gen_bench.sv
`timescale 1ns/1ps
module iob_strobe_gen_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] io_addr = '0;
   logic        io_rd = 1'b0, io_wr = 1'b0;
   logic        io_ready;
   logic [4:0]  io_addr_lo;
   logic        cfg_wr = 1'b0;
   logic [3:0]  cfg_sel = '0;
   logic [7:0]  cfg_wdata = '0;
   logic [7:0]  pin_out, pin_oe;

   always #2 clk = ~clk;

   iob_strobe_gen u_iob_strobe_gen (
      .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_rd(io_rd),
      .io_wr(io_wr), .io_ready(io_ready), .io_addr_lo(io_addr_lo),
      .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
      .pin_out(pin_out), .pin_oe(pin_oe)
   );

   int n_checks = 0;
   int n_errors = 0;

   logic [7:0] m_ctrl [8];
   logic [7:0] m_ddr = '0, m_fr = '0, m_gd = '0;

   int         q_len  [$];
   logic [7:0] q_pins [$];
   logic [7:0] q_oe   [$];
   string      q_tag  [$];

   task automatic check(input bit ok, input string tag, input logic [31:0] act,
                        input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic predict(input logic [15:0] a, input bit rd, input string tag);
      logic [7:0] c;
      logic [2:0] b;
      bit         match, fire;
      logic [7:0] p;
      b = a[15:13];
      c = m_ctrl[b];
      case (c[5:4])
         2'b01:   match = rd;
         2'b10:   match = !rd;
         default: match = 1'b1;
      endcase
      fire = match && !(c[3] && !rd);
      for (int i = 0; i < 8; i++) begin
         if (m_ddr[i] && m_fr[i]) p[i] = !(fire && b == 3'(i));
         else                     p[i] = m_gd[i];
      end
      q_len.push_back(fire ? 1 + ((2 << c[7:6]) - 1) : 1);
      q_pins.push_back(p);
      q_oe.push_back(m_ddr);
      q_tag.push_back(tag);
   endtask

   task automatic do_acc(input logic [15:0] a, input bit rd, input string tag);
      predict(a, rd, tag);
      @(negedge clk);
      io_addr = a; io_rd = rd; io_wr = !rd;
      #1;
      while (!io_ready) begin
         @(negedge clk); #1;
      end
      @(negedge clk);
      io_rd = 1'b0; io_wr = 1'b0;
   endtask

   task automatic cfg_write(input logic [3:0] sel, input logic [7:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_sel = sel; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic cfg_set(input logic [3:0] sel, input logic [7:0] d);
      cfg_write(sel, d);
      if (sel < 4'd8)        m_ctrl[sel[2:0]] = d;
      else if (sel == 4'd8)  m_ddr = d;
      else if (sel == 4'd9)  m_fr = d;
      else if (sel == 4'd10) m_gd = d;
   endtask

   // monitor: pops expected items and compares the access as it runs
   initial begin
      bit         in_acc = 0;
      bit         pins_ok = 1;
      int         cyc = 0;
      int         e_len = 0;
      logic [7:0] e_pins = '0, e_oe = '0, bad_pins = '0;
      string      e_tag;
      forever begin
         @(negedge clk); #1;
         if (!in_acc && (io_rd || io_wr)) begin
            if (q_len.size() == 0) begin
               check(0, "scoreboard empty", 0, 1);
            end else begin
               in_acc  = 1; cyc = 0; pins_ok = 1;
               e_len   = q_len.pop_front();
               e_pins  = q_pins.pop_front();
               e_oe    = q_oe.pop_front();
               e_tag   = q_tag.pop_front();
            end
         end
         if (in_acc) begin
            cyc++;
            if (pin_out !== e_pins || pin_oe !== e_oe) begin
               if (pins_ok) bad_pins = pin_out;
               pins_ok = 0;
            end
            if (io_ready === 1'b1 || cyc > 40) begin
               check(cyc == e_len, {e_tag, " length"}, cyc, e_len);
               check(pins_ok, {"R11 pins ", e_tag}, bad_pins, e_pins);
               in_acc = 0;
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      check(0, "watchdog", 0, 1);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

   initial begin
      for (int i = 0; i < 8; i++) m_ctrl[i] = '0;
      io_addr = 16'h1234;
      repeat (3) @(negedge clk);
      #1;
      check(pin_oe == 8'h00, "R8 reset oe", pin_oe, 8'h00);
      check(io_ready == 1'b1, "R8 reset ready", io_ready, 1);
      check(pin_out == 8'h00, "R8 reset pins", pin_out, 8'h00);
      check(io_addr_lo == 5'h14, "R2 low addr", io_addr_lo, 5'h14);
      @(negedge clk);
      rst_n = 1'b1;
      do_acc(16'h0000, 1, "R8 default bank");

      cfg_set(4'd8, 8'hFF);
      cfg_set(4'd9, 8'h44);
      cfg_set(4'd2, 8'h50);
      cfg_set(4'd6, 8'h60);
      @(negedge clk); #1;
      check(pin_out == 8'h44, "R7 idle strobe pins", pin_out, 8'h44);
      check(pin_oe == 8'hFF, "R7 idle oe", pin_oe, 8'hFF);
      io_addr = 16'hC01F; #1;
      check(io_addr_lo == 5'h1F, "R2 low addr", io_addr_lo, 5'h1F);

      do_acc(16'h4003, 1, "R1 R3 bank2 read");
      do_acc(16'hC01F, 0, "R1 R3 bank6 write");
      do_acc(16'h4000, 0, "R4 R5 write to read bank");
      do_acc(16'hC000, 1, "R4 R5 read from write bank");

      cfg_set(4'd2, 8'hF0);
      do_acc(16'h4010, 1, "R3 R4 both read 15 waits");
      do_acc(16'h4011, 0, "R3 R4 both write 15 waits");

      cfg_set(4'd6, 8'h08);
      do_acc(16'hC004, 0, "R6 protected write");
      do_acc(16'hC004, 1, "R6 protected read");

      cfg_set(4'd2, 8'h90);
      do_acc(16'h4002, 1, "R3 7 waits");

      cfg_set(4'd5, 8'h30);
      cfg_set(4'd10, 8'h20);
      @(negedge clk); #1;
      check(pin_out == 8'h64, "R7 gpio data", pin_out, 8'h64);
      do_acc(16'hA000, 1, "R7 gpio bank keeps data");
      cfg_set(4'd8, 8'hDF);
      @(negedge clk); #1;
      check(pin_oe == 8'hDF, "R7 input pin oe", pin_oe, 8'hDF);

      cfg_write(4'd11, 8'hFF);
      cfg_write(4'd15, 8'h00);
      @(negedge clk); #1;
      check(pin_out == 8'h64 && pin_oe == 8'hDF, "R10 ignored select",
            {pin_out, pin_oe}, {8'h64, 8'hDF});
      do_acc(16'h4000, 1, "R10 control unchanged");

      // same cycle: write ctrl2 while a bank2 access starts
      fork
         do_acc(16'h4000, 1, "R9 same-cycle old value");
         cfg_write(4'd2, 8'h50);
      join
      m_ctrl[2] = 8'h50;
      do_acc(16'h4000, 1, "R9 new value next access");

      // write during a long access
      cfg_set(4'd2, 8'h90);
      fork
         do_acc(16'h4001, 1, "R9 write during access");
         begin
            @(negedge clk);
            cfg_write(4'd2, 8'h40);
            cfg_wr = 1'b1; cfg_sel = 4'd9; cfg_wdata = 8'h40;
            @(negedge clk);
            cfg_wr = 1'b0;
         end
      join
      m_ctrl[2] = 8'h40;
      m_fr = 8'h40;
      do_acc(16'h4001, 0, "R9 R7 after write, pin now gpio");

      repeat (4) @(negedge clk);
      check(q_len.size() == 0, "scoreboard drained", q_len.size(), 0);
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule